// File: doc/BRIEF.md
# STM-1 Frame Aligner

This block takes an STM-1 line signal that has already been cut into bytes and finds where each 125 us frame begins. A frame is 9 rows of 270 byte columns, 2430 bytes in total, sent row by row with the columns of each row in order from left to right. The block locks onto the frame by looking for the six-byte alignment word: three bytes of 0xF6 followed by three bytes of 0x28. That word opens the first row of every frame.

Once locked, the block tells downstream overhead logic the row and column of every byte it accepts. It also raises a start-of-frame strobe on the first byte of each frame. It checks the alignment word once per frame. Repeated misses drop it into an out-of-frame condition and send it back to searching. If out-of-frame lasts long enough, a loss-of-frame flag is raised, which downstream logic uses to insert its alarm indication signal. Cycles with the valid input low carry no byte and are skipped completely.

Top module: `sdh_frame_aligner`

## Requirements
- R1: After reset, `outOfFrame` is 1, `lossOfFrame` is 0, and `frameStart` is 0.
- R2: While searching, when six consecutive valid bytes equal 0xF6, 0xF6, 0xF6, 0x28, 0x28, 0x28, the next valid byte is reported at row 0, column 6. Rows are numbered 0 to 8 and columns 0 to 269. No other byte sequence causes a lock.
- R3: For each valid byte, the column advances by one. After column 269 the column wraps to 0 and the row advances. After row 8, column 269 the position returns to row 0, column 0.
- R4: A cycle with `dataValid` low does not move the position, does not assert `frameStart`, and does not enter the pattern window. An alignment word split by idle cycles is still found.
- R5: After a lock from searching, `outOfFrame` clears only after 2 consecutive frames whose alignment word is correct at its expected position. The word is judged on the byte at row 0, column 5. A miss during this confirmation returns the block to searching.
- R6: While in frame, `outOfFrame` is set after 4 consecutive frames with a wrong alignment word at the expected position. A correct frame restarts that count.
- R7: `lossOfFrame` is set after out-of-frame has held for 24 frames' worth of valid bytes (24 x 2430) in a row. The frame count is a parameter.
- R8: `lossOfFrame` clears after in-frame has held for 24 x 2430 valid bytes in a row. The frame count is a parameter.
- R9: `frameStart` is high for exactly the valid byte at row 0, column 0, but only while confirming or in frame. It is never high while searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 8 | Received byte, already byte aligned |
| dataValid | input | 1 | `dataIn` carries a byte this cycle |
| frameStart | output | 1 | First byte of a frame (R9) |
| rowIdx | output | 4 | Row of the current byte, 0 to 8 |
| colIdx | output | 9 | Column of the current byte, 0 to 269 |
| outOfFrame | output | 1 | 1 while searching or confirming; in frame when 0 |
| lossOfFrame | output | 1 | Sustained out-of-frame indication |

## Verification
A position counter that slips by even one byte shows up on `rowIdx`/`colIdx` in the same cycle. Within one frame it also moves `frameStart` and makes the next alignment check fail. A wrong miss or confirm count changes the exact frame on which `outOfFrame` flips, so the bench checks status at frame boundaries on both sides of each threshold. A loss-of-frame timer that is off by one byte is caught by sampling the flag one byte before, and on, the byte where it must change.

// File: rtl/sdhfa_pkg.sv
package sdhfa_pkg;

  // Alignment state of the detector
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2
  } alignState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic huntMode;   // searching: no frame strobe
    logic loadAlign;  // reload position so next byte is row 0, col PAT_LEN
  } ctrlStrobe_t;

  // Observations from datapath to control
  typedef struct packed {
    logic patMatch;   // last PAT_LEN valid bytes (incl. current) form the word
    logic atCheck;    // current byte sits on the last alignment-word column
  } dpStatus_t;

endpackage

// File: rtl/sdhfa_datapath.sv
module sdhfa_datapath
  import sdhfa_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int NUM_A = 3,
  parameter logic [7:0] A1_VAL = 8'hF6,
  parameter logic [7:0] A2_VAL = 8'h28,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       dataIn,
  input  logic             dataValid,
  input  ctrlStrobe_t      ctrl,
  output dpStatus_t        dpSt,
  output logic [ROW_W-1:0] rowIdx,
  output logic [COL_W-1:0] colIdx,
  output logic             frameStart
);

  localparam int PAT_LEN = 2 * NUM_A;
  localparam int HIST_W = 8 * (PAT_LEN - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [COL_W-1:0] COL_LOAD = COL_W'(PAT_LEN);
  localparam logic [COL_W-1:0] COL_CHECK = COL_W'(PAT_LEN - 1);

  // ---------------- pattern window ----------------
  logic [HIST_W-1:0]    histQ;
  logic [8*PAT_LEN-1:0] windowBytes;
  logic [PAT_LEN-1:0]   byteHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (dataValid) begin
      histQ <= {histQ[HIST_W-9:0], dataIn};
    end
  end

  assign windowBytes = {histQ, dataIn};

  // byte k = 0 is the oldest in the window
  for (genvar k = 0; k < PAT_LEN; k++) begin : g_cmp
    localparam logic [7:0] EXP_BYTE = (k < NUM_A) ? A1_VAL : A2_VAL;
    assign byteHit[k] = (windowBytes[8*(PAT_LEN-1-k) +: 8] == EXP_BYTE);
  end

  assign dpSt.patMatch = &byteHit;

  // ---------------- position counters ----------------
  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else if (dataValid) begin
      if (ctrl.loadAlign) begin
        rowQ <= '0;
        colQ <= COL_LOAD;
      end else if (colQ == COL_LAST) begin
        colQ <= '0;
        rowQ <= (rowQ == ROW_LAST) ? '0 : rowQ + ROW_W'(1);
      end else begin
        colQ <= colQ + COL_W'(1);
      end
    end
  end

  assign dpSt.atCheck = (rowQ == '0) && (colQ == COL_CHECK);
  assign rowIdx       = rowQ;
  assign colIdx       = colQ;
  assign frameStart   = dataValid && !ctrl.huntMode && (rowQ == '0) && (colQ == '0);

  // ---------------- assertions ----------------
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> ($stable(rowQ) && $stable(colQ)))
    else $error("a_r4_idle_hold");

  a_r3_col_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !ctrl.loadAlign && colQ == COL_LAST) |=> (colQ == '0))
    else $error("a_r3_col_wrap");

  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !ctrl.loadAlign && colQ == COL_LAST && rowQ == ROW_LAST)
      |=> (rowQ == '0))
    else $error("a_r3_frame_wrap");

  a_r2_load_target: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && ctrl.loadAlign) |=> (rowQ == '0 && colQ == COL_LOAD))
    else $error("a_r2_load_target");

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (rowQ <= ROW_LAST) && (colQ <= COL_LAST))
    else $error("a_r3_in_range");

endmodule

// File: rtl/sdhfa_control.sv
module sdhfa_control
  import sdhfa_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int OOF_FRAMES = 4,
  parameter int INF_FRAMES = 2,
  parameter int LOF_FRAMES = 24,
  parameter int LOF_CLR_FRAMES = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataValid,
  input  dpStatus_t   dpSt,
  output ctrlStrobe_t ctrl,
  output logic        outOfFrame,
  output logic        lossOfFrame
);

  localparam int FRAME_BYTES = ROWS * COLS;
  localparam int SET_BYTES = LOF_FRAMES * FRAME_BYTES;
  localparam int CLR_BYTES = LOF_CLR_FRAMES * FRAME_BYTES;
  localparam int MAX_BYTES = (SET_BYTES > CLR_BYTES) ? SET_BYTES : CLR_BYTES;
  localparam int TMR_W = $clog2(MAX_BYTES + 1);
  localparam int GOOD_W = $clog2(INF_FRAMES + 1);
  localparam int ERR_W = $clog2(OOF_FRAMES + 1);
  localparam logic [TMR_W-1:0] SET_LAST = TMR_W'(SET_BYTES - 1);
  localparam logic [TMR_W-1:0] CLR_LAST = TMR_W'(CLR_BYTES - 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(INF_FRAMES - 1);
  localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(OOF_FRAMES - 1);

  alignState_e       stateQ;
  logic [GOOD_W-1:0] goodCntQ;
  logic [ERR_W-1:0]  errCntQ;
  logic [TMR_W-1:0]  lofTmrQ;
  logic              lofQ;
  logic              checkNow;
  logic              timerRun;
  logic [TMR_W-1:0]  timerLast;

  assign checkNow = dataValid && dpSt.atCheck;

  // ---------------- alignment state machine ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_HUNT;
      goodCntQ <= '0;
      errCntQ  <= '0;
    end else if (dataValid) begin
      case (stateQ)
        ST_HUNT: begin
          if (dpSt.patMatch) begin
            stateQ   <= ST_CONFIRM;
            goodCntQ <= '0;
          end
        end
        ST_CONFIRM: begin
          if (checkNow) begin
            if (!dpSt.patMatch) begin
              stateQ <= ST_HUNT;
            end else if (goodCntQ == GOOD_LAST) begin
              stateQ  <= ST_SYNC;
              errCntQ <= '0;
            end else begin
              goodCntQ <= goodCntQ + GOOD_W'(1);
            end
          end
        end
        ST_SYNC: begin
          if (checkNow) begin
            if (dpSt.patMatch) begin
              errCntQ <= '0;
            end else if (errCntQ == ERR_LAST) begin
              stateQ <= ST_HUNT;
            end else begin
              errCntQ <= errCntQ + ERR_W'(1);
            end
          end
        end
        default: stateQ <= ST_HUNT;
      endcase
    end
  end

  assign outOfFrame     = (stateQ != ST_SYNC);
  assign ctrl.huntMode  = (stateQ == ST_HUNT);
  assign ctrl.loadAlign = dataValid && (stateQ == ST_HUNT) && dpSt.patMatch;

  // ---------------- loss-of-frame timer ----------------
  // Runs while the status disagrees with the flag; any agreeing byte restarts it.
  assign timerRun  = outOfFrame != lofQ;
  assign timerLast = lofQ ? CLR_LAST : SET_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lofTmrQ <= '0;
      lofQ    <= 1'b0;
    end else if (dataValid) begin
      if (!timerRun) begin
        lofTmrQ <= '0;
      end else if (lofTmrQ == timerLast) begin
        lofTmrQ <= '0;
        lofQ    <= ~lofQ;
      end else begin
        lofTmrQ <= lofTmrQ + TMR_W'(1);
      end
    end
  end

  assign lossOfFrame = lofQ;

  // ---------------- assertions ----------------
  a_r6_oof_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outOfFrame) |-> $past(checkNow && !dpSt.patMatch))
    else $error("a_r6_oof_on_miss");

  a_r5_lock_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outOfFrame) |-> $past(checkNow && dpSt.patMatch))
    else $error("a_r5_lock_on_hit");

  a_r7_lof_needs_oof: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lossOfFrame) |-> $past(outOfFrame && dataValid))
    else $error("a_r7_lof_needs_oof");

  a_r8_lof_clear_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossOfFrame) |-> $past(!outOfFrame && dataValid))
    else $error("a_r8_lof_clear_in_frame");

  a_r4_idle_no_change: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> ($stable(stateQ) && $stable(lossOfFrame)))
    else $error("a_r4_idle_no_change");

endmodule

// File: rtl/sdh_frame_aligner.sv
module sdh_frame_aligner
  import sdhfa_pkg::*;
#(
  parameter int ROWS = 9,
  parameter int COLS = 270,
  parameter int NUM_A = 3,
  parameter logic [7:0] A1_VAL = 8'hF6,
  parameter logic [7:0] A2_VAL = 8'h28,
  parameter int OOF_FRAMES = 4,
  parameter int INF_FRAMES = 2,
  parameter int LOF_FRAMES = 24,
  parameter int LOF_CLR_FRAMES = 24,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       dataIn,
  input  logic             dataValid,
  output logic             frameStart,
  output logic [ROW_W-1:0] rowIdx,
  output logic [COL_W-1:0] colIdx,
  output logic             outOfFrame,
  output logic             lossOfFrame
);

  ctrlStrobe_t ctrl;
  dpStatus_t   dpSt;

  sdhfa_datapath #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .NUM_A  (NUM_A),
    .A1_VAL (A1_VAL),
    .A2_VAL (A2_VAL)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .dataIn     (dataIn),
    .dataValid  (dataValid),
    .ctrl       (ctrl),
    .dpSt       (dpSt),
    .rowIdx     (rowIdx),
    .colIdx     (colIdx),
    .frameStart (frameStart)
  );

  sdhfa_control #(
    .ROWS           (ROWS),
    .COLS           (COLS),
    .OOF_FRAMES     (OOF_FRAMES),
    .INF_FRAMES     (INF_FRAMES),
    .LOF_FRAMES     (LOF_FRAMES),
    .LOF_CLR_FRAMES (LOF_CLR_FRAMES)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .dataValid   (dataValid),
    .dpSt        (dpSt),
    .ctrl        (ctrl),
    .outOfFrame  (outOfFrame),
    .lossOfFrame (lossOfFrame)
  );

endmodule

// File: tb/test_sdh_frame_aligner.sv
`timescale 1ns/1ps
module test_sdh_frame_aligner;

  localparam int NCOL = 270;
  localparam int FBYTES = 9 * NCOL;
  localparam int LOF_F = 3;
  localparam int LBYTES = LOF_F * FBYTES;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic       dataValid = 1'b0;
  logic       frameStart;
  logic [3:0] rowIdx;
  logic [8:0] colIdx;
  logic       outOfFrame;
  logic       lossOfFrame;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  sdh_frame_aligner #(
    .LOF_FRAMES     (LOF_F),
    .LOF_CLR_FRAMES (LOF_F)
  ) i_sdh_frame_aligner (
    .clk         (clk),
    .rstN        (rstN),
    .dataIn      (dataIn),
    .dataValid   (dataValid),
    .frameStart  (frameStart),
    .rowIdx      (rowIdx),
    .colIdx      (colIdx),
    .outOfFrame  (outOfFrame),
    .lossOfFrame (lossOfFrame)
  );

  typedef struct {
    bit    chkPos;
    int    expRow;
    int    expCol;
    bit    expSof;
    string tag;
  } item_t;

  item_t expQ[$];

  // ---------------- driver ----------------
  task automatic putByte(input logic [7:0] d, input bit v, input bit chk,
                         input int r, input int c, input bit s, input string tag);
    item_t it;
    @(negedge clk);
    dataIn    = d;
    dataValid = v;
    it.chkPos = chk; it.expRow = r; it.expCol = c; it.expSof = s; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    putByte(8'h00, 1'b0, 1'b0, 0, 0, 1'b0, tag);
  endtask

  function automatic logic [7:0] filler(input int i);
    return 8'h50 + 8'(i % 16);
  endfunction

  task automatic sendFill(input int n, input string tag);
    for (int i = 0; i < n; i++) putByte(filler(i), 1'b1, 1'b0, 0, 0, 1'b0, tag);
  endtask

  // bad: first alignment byte corrupted
  task automatic sendFrame(input bit bad, input int firstIdx, input int lastIdx,
                           input int chkFrom, input bit sofFirst, input int gapEvery,
                           input string tag);
    for (int i = firstIdx; i <= lastIdx; i++) begin
      logic [7:0] d;
      if (gapEvery > 0 && (i % gapEvery) == gapEvery - 1) idle(tag);
      if (i < 3) d = (bad && i == 0) ? 8'h00 : 8'hF6;
      else if (i < 6) d = 8'h28;
      else d = filler(i);
      putByte(d, 1'b1, i >= chkFrom, i / NCOL, i % NCOL, (i == 0) && sofFirst, tag);
    end
  endtask

  task automatic fullFrame(input bit bad, input int chkFrom, input bit sofFirst,
                           input string tag);
    sendFrame(bad, 0, FBYTES - 1, chkFrom, sofFirst, 0, tag);
  endtask

  task automatic checkFlags(input bit expOof, input bit expLof, input string tag);
    idle(tag);
    #1;
    checks++;
    if (outOfFrame !== expOof) begin
      fails++;
      $display("FAIL %s outOfFrame actual=%0b expected=%0b", tag, outOfFrame, expOof);
    end
    checks++;
    if (lossOfFrame !== expLof) begin
      fails++;
      $display("FAIL %s lossOfFrame actual=%0b expected=%0b", tag, lossOfFrame, expLof);
    end
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (frameStart !== it.expSof) begin
        fails++;
        $display("FAIL %s R9 frameStart actual=%0b expected=%0b", it.tag, frameStart, it.expSof);
      end
      if (it.chkPos) begin
        checks++;
        if (int'(rowIdx) != it.expRow || int'(colIdx) != it.expCol) begin
          fails++;
          $display("FAIL %s R3 position actual=%0d/%0d expected=%0d/%0d",
                   it.tag, rowIdx, colIdx, it.expRow, it.expCol);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // ---------------- scenario ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (outOfFrame !== 1'b1 || lossOfFrame !== 1'b0 || frameStart !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset oof/lof/sof actual=%0b%0b%0b expected=100",
               outOfFrame, lossOfFrame, frameStart);
    end
    @(negedge clk);
    rstN = 1'b1;
    checkFlags(1'b1, 1'b0, "R1");

    // search, lock and confirm
    sendFill(100, "R2");
    checkFlags(1'b1, 1'b0, "R2_no_false_lock");
    fullFrame(1'b0, 6, 1'b0, "R2");           // lock: byte after word is col 6
    checkFlags(1'b1, 1'b0, "R5_first_confirm");
    fullFrame(1'b0, 0, 1'b1, "R3");
    checkFlags(1'b1, 1'b0, "R5_one_good");
    fullFrame(1'b0, 0, 1'b1, "R9");
    checkFlags(1'b0, 1'b0, "R5_in_frame");

    // idle cycles inside a frame
    sendFrame(1'b0, 0, FBYTES - 1, 0, 1'b1, 7, "R4");
    checkFlags(1'b0, 1'b0, "R4_gaps");

    // out-of-frame with count restart
    for (int f = 0; f < 3; f++) fullFrame(1'b1, 0, 1'b1, "R6");
    fullFrame(1'b0, 0, 1'b1, "R6");
    for (int f = 0; f < 3; f++) fullFrame(1'b1, 0, 1'b1, "R6");
    checkFlags(1'b0, 1'b0, "R6_three_misses");
    fullFrame(1'b1, 0, 1'b1, "R6");
    checkFlags(1'b1, 1'b0, "R6_fourth_miss");

    // loss of frame: 2424 oof bytes already counted
    sendFill(LBYTES - (FBYTES - 6) - 1, "R7");
    checkFlags(1'b1, 1'b0, "R7_one_short");
    sendFill(1, "R7");
    checkFlags(1'b1, 1'b1, "R7_declared");

    // relock at a new offset, word split by idle cycles
    sendFill(37, "R2");
    sendFrame(1'b0, 0, FBYTES - 1, 6, 1'b0, 2, "R4_split_word");
    fullFrame(1'b1, 0, 1'b1, "R5");            // confirmation miss
    checkFlags(1'b1, 1'b1, "R5_confirm_miss");
    fullFrame(1'b0, 6, 1'b0, "R9_hunt_no_sof");
    fullFrame(1'b0, 0, 1'b1, "R5");
    checkFlags(1'b1, 1'b1, "R5_relock_one");
    fullFrame(1'b0, 0, 1'b1, "R5");
    checkFlags(1'b0, 1'b1, "R5_relock_done");

    // loss of frame clearing: 2424 in-frame bytes already counted
    fullFrame(1'b0, 0, 1'b1, "R8");
    fullFrame(1'b0, 0, 1'b1, "R8");
    checkFlags(1'b0, 1'b1, "R8_held");
    sendFrame(1'b0, 0, 4, 0, 1'b1, 0, "R8");
    checkFlags(1'b0, 1'b1, "R8_one_short");
    sendFrame(1'b0, 5, 5, 0, 1'b1, 0, "R8");
    checkFlags(1'b0, 1'b0, "R8_cleared");
    sendFrame(1'b0, 6, FBYTES - 1, 0, 1'b1, 0, "R3");
    fullFrame(1'b0, 0, 1'b1, "R3_wrap");
    checkFlags(1'b0, 1'b0, "R8_stays_clear");

    repeat (3) idle("end");
    @(negedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule